// File: doc/BRIEF.md
# Double-Buffered Converter Bus Front End

This block is the digital front end of a 16-bit voltage-output converter attached to a parallel processor bus. A bus word is first captured in an input register. A separate strobe then moves it into a converter register that drives the analog core. Because the two stages have separate enables, a host can preload many converters one at a time. It can then update all of them together with one shared transfer strobe.

Every control is active low. The input register captures while its select and the write strobe are both low. The converter register captures from the input register while its own select and the write strobe are both low. With both selects and the write strobe low, the path is transparent. A clear input empties both registers, which gives mid-scale. The bus uses two's-complement coding, and the block presents offset-binary code to the core by inverting the MSB.

Level-sensitive latching is modelled in one clock domain. A register loads on every clock edge at which its condition holds, and otherwise keeps its value.

Top module: `dac_bus_frontend`

## Requirements
- R1: After reset both registers hold 0000h, so `core_code_o` reads 8000h (mid-scale).
- R2: The input register loads `data_i` on each clock edge at which `in_sel_ni` and `wr_ni` are both 0 and `clr_ni` is 1.
- R3: The converter register loads the input register's value on each edge at which `dac_sel_ni` and `wr_ni` are both 0 and `clr_ni` is 1. Without that condition, `core_code_o` does not change except through a clear.
- R4: While `wr_ni` is 1, changes on `data_i`, `in_sel_ni` and `dac_sel_ni` have no effect on `core_code_o`, neither now nor after a later transfer.
- R5: An edge with `clr_ni` at 0 sets both registers to 0000h. The next `core_code_o` reads 8000h, and a later transfer with no new load also gives 8000h.
- R6: A clear wins over both load conditions. Data on the bus during a clear never reaches either register.
- R7: `core_code_o` equals the converter register with bit 15 inverted. A bus value of 7FFFh gives FFFFh, 8000h gives 0000h, and 0000h gives 8000h.
- R8: With `in_sel_ni`, `dac_sel_ni` and `wr_ni` all 0 and `clr_ni` at 1, a steady bus word appears at `core_code_o` (converted per R7) two clock edges after it is applied.
- R9: A transfer with `in_sel_ni` at 1 moves the previously loaded word and ignores the current `data_i`.
- R10: Every low pulse on `wr_ni` lasts at least WR_MIN_CYC clock cycles (default 2). This is the minimum that lets a single-buffered write pass through both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Bus word, two's complement |
| in_sel_ni | input | 1 | Input register select, active low |
| dac_sel_ni | input | 1 | Converter register select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| clr_ni | input | 1 | Clear to mid-scale, active low |
| core_code_o | output | 16 | Offset-binary code to converter core |

## Verification
The block is exercised in three modes. Buffered sequences show whether the two stages really act separately: a preloaded word must stay hidden until a transfer. Transparent and single-buffered sequences check the two-edge latency. Extreme codes (7FFFh, 8000h, 0000h) separate a correct MSB inversion from a pass-through or a full inversion. Random control mixes, including clears that overlap loads, test clear priority and hold behaviour against a bench model built from the requirements.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // decoded, active-high controls for one cycle
  typedef struct packed {
    logic clr;
    logic ld_in;
    logic ld_dac;
  } dacfe_ctl_t;
endpackage

// File: rtl/dacfe_ctl.sv
module dacfe_ctl
  import dacfe_pkg::*;
(
  input  logic       in_sel_ni,
  input  logic       dac_sel_ni,
  input  logic       wr_ni,
  input  logic       clr_ni,
  output dacfe_ctl_t ctl_o
);
  logic wr_act;

  assign wr_act       = ~wr_ni & clr_ni;
  assign ctl_o.clr    = ~clr_ni;
  assign ctl_o.ld_in  = wr_act & ~in_sel_ni;
  assign ctl_o.ld_dac = wr_act & ~dac_sel_ni;
endmodule

// File: rtl/dacfe_stage.sv
module dacfe_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (clr_i) q_q <= '0;
    else if (ld_i)  q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dacfe_code.sv
module dacfe_code #(
  parameter int unsigned W      = 16,
  parameter bit          TWOS_IN = 1'b1
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MsbMask = {1'b1, {(W-1){1'b0}}};

  generate
    if (TWOS_IN) begin : g_twos
      assign q_o = d_i ^ MsbMask;
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/dac_bus_frontend.sv
module dac_bus_frontend
  import dacfe_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned WR_MIN_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              in_sel_ni,
  input  logic              dac_sel_ni,
  input  logic              wr_ni,
  input  logic              clr_ni,
  output logic [DATA_W-1:0] core_code_o
);
  dacfe_ctl_t        ctl;
  logic [DATA_W-1:0] in_word;
  logic [DATA_W-1:0] dac_word;

  dacfe_ctl i_ctl (
    .in_sel_ni (in_sel_ni),
    .dac_sel_ni(dac_sel_ni),
    .wr_ni     (wr_ni),
    .clr_ni    (clr_ni),
    .ctl_o     (ctl)
  );

  dacfe_stage #(.W(DATA_W)) i_in_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ctl.clr),
    .ld_i  (ctl.ld_in),
    .d_i   (data_i),
    .q_o   (in_word)
  );

  // second stage sees the first stage's pre-edge value
  dacfe_stage #(.W(DATA_W)) i_dac_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ctl.clr),
    .ld_i  (ctl.ld_dac),
    .d_i   (in_word),
    .q_o   (dac_word)
  );

  dacfe_code #(.W(DATA_W), .TWOS_IN(1'b1)) i_code (
    .d_i(dac_word),
    .q_o(core_code_o)
  );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned WR_MIN_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              in_sel_ni,
  input logic              dac_sel_ni,
  input logic              wr_ni,
  input logic              clr_ni,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] core_code_o
);
  localparam logic [DATA_W-1:0] Mid = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int unsigned CW = $clog2(WR_MIN_CYC + 1) + 1;

  logic [CW-1:0] wr_run_q;
  logic          xfer, transp;

  assign xfer   = !dac_sel_ni && !wr_ni && clr_ni;
  assign transp = xfer && !in_sel_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    wr_run_q <= CW'(WR_MIN_CYC);
    else if (wr_ni)                 wr_run_q <= '0;
    else if (wr_run_q < CW'(WR_MIN_CYC)) wr_run_q <= wr_run_q + 1'b1;
  end

  p_clr_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> core_code_o == Mid);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni && clr_ni) |=> $stable(core_code_o));

  p_no_xfer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_sel_ni && clr_ni) |=> $stable(core_code_o));

  p_xfer_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> core_code_o == ($past(in_word) ^ Mid));

  p_transp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (transp && $past(transp) && $stable(data_i)) |=> core_code_o == ($past(data_i) ^ Mid));

  p_wr_width_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_ni) |-> wr_run_q >= CW'(WR_MIN_CYC));
endmodule

bind dac_bus_frontend dacfe_checker #(
  .DATA_W    (DATA_W),
  .WR_MIN_CYC(WR_MIN_CYC)
) i_dacfe_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .in_sel_ni  (in_sel_ni),
  .dac_sel_ni (dac_sel_ni),
  .wr_ni      (wr_ni),
  .clr_ni     (clr_ni),
  .in_word    (in_word),
  .core_code_o(core_code_o)
);

// File: tb/test_dac_bus_frontend.sv
`timescale 1ns/1ps
module test_dac_bus_frontend;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        in_sel_ni = 1'b1, dac_sel_ni = 1'b1, wr_ni = 1'b1, clr_ni = 1'b1;
  logic [15:0] core_code_o;

  int total = 0, bad = 0;
  logic [15:0] m_in = '0, m_dac = '0;

  always #2.5 clk_i = ~clk_i;

  dac_bus_frontend i_dac_bus_frontend (
    .clk_i, .rst_ni, .data_i, .in_sel_ni, .dac_sel_ni, .wr_ni, .clr_ni, .core_code_o
  );

  function automatic logic [15:0] to_core(input logic [15:0] w);
    return {~w[15], w[14:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    total++;
    if (core_code_o !== exp) begin
      bad++;
      $display("FAIL %s core_code_o=%h expected=%h", tag, core_code_o, exp);
    end
  endtask

  // drive one cycle after a negedge, model the edge, check at next negedge
  task automatic cyc(input string tag, input logic [15:0] d,
                     input logic a0, input logic a1, input logic wr, input logic clr);
    logic [15:0] old_in;
    data_i = d; in_sel_ni = a0; dac_sel_ni = a1; wr_ni = wr; clr_ni = clr;
    @(negedge clk_i);
    old_in = m_in;
    if (!clr) begin
      m_in = '0; m_dac = '0;
    end else if (!wr) begin
      if (!a0) m_in = d;
      if (!a1) m_dac = old_in;
    end
    check(tag, to_core(m_dac));
  endtask

  task automatic idle(input string tag, input logic [15:0] d);
    cyc(tag, d, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 5.0);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0715));
    repeat (3) @(negedge clk_i);
    total++;
    if (core_code_o !== 16'h8000) begin
      bad++; $display("FAIL R1 reset core_code_o=%h expected=8000", core_code_o);
    end
    rst_ni = 1'b1;
    idle("R1", 16'h1111);

    // buffered: preload stays hidden
    repeat (2) cyc("R2", 16'h7fff, 1'b0, 1'b1, 1'b0, 1'b1);
    idle("R4", 16'h0abc);
    repeat (2) cyc("R3", 16'h2222, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7 7FFF->FFFF", 16'hffff);
    repeat (2) cyc("R2", 16'h8000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R3 no transfer", 16'hffff);
    cyc("R4", 16'h5555, 1'b0, 1'b0, 1'b1, 1'b1);
    cyc("R4", 16'h3333, 1'b0, 1'b1, 1'b1, 1'b1);
    repeat (2) cyc("R9", 16'h4444, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7 8000->0000", 16'h0000);
    repeat (2) cyc("R9", 16'h6666, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9 old word kept", 16'h0000);

    // transparent: two-edge latency
    cyc("R8", 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 first edge", 16'h0000);
    cyc("R8", 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 second edge", 16'h9234);
    idle("R4", 16'hffff);

    // clear overlapping every load
    cyc("R6", 16'h7abc, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 clr mid", 16'h8000);
    cyc("R6", 16'h7abc, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) cyc("R5", 16'h1357, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R5 cleared input", 16'h8000);

    // single-buffered, minimum WR width, 0000h -> mid
    repeat (2) cyc("R10", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 0000->8000", 16'h8000);
    repeat (2) cyc("R10", 16'hfedc, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10 single buffered", 16'h7edc);
    idle("R4", 16'h0);

    // random control mixes, WR held in 2-cycle blocks
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      logic a0, a1, wr, clr;
      d   = 16'($urandom);
      a0  = 1'($urandom);
      a1  = 1'($urandom);
      wr  = 1'($urandom);
      clr = ($urandom % 8) != 0;
      repeat (2) cyc("R2/R3/R6 random", d, a0, a1, wr, clr);
      if ($urandom % 4 == 0) idle("R4 random", 16'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule